// File: doc/BRIEF.md
# Pre/Post-Trigger Capture Controller

This block drives the write side of a circular sample memory in a logic analyzer. Each cycle with the sample enable high writes one sample word into a synchronous single-port RAM. The word goes to the current write address, and that address then advances by one, wrapping around the buffer. Arming the block clears the address and loads a pre-trigger size, given as a whole number of fixed-size segments. The block then fills that many samples before it will accept a trigger. After the fill it keeps writing around the ring until a trigger arrives. The trigger comes from an internal trigger unit, or from an external pin when that pin is enabled.

The sample written in the trigger cycle is the first post-trigger sample. The block captures the rest of the buffer, which is the segments not reserved for pre-trigger data, and then stops. It raises done and drops write enable. It also holds the address of the trigger sample, so readout can start at that address minus the pre-trigger size, which is the oldest sample. The buffer is 2^AW words, cut into 2^(AW-SEG_LOG) segments of 2^SEG_LOG words each. The defaults are 128K words in sixteen 8K segments.

Top module: `capture_ctrl`

## Requirements
- R1: After reset the block is idle: ram_we=0, done=0, ram_addr=0 and trig_addr=0.
- R2: ram_we is 1 exactly when smp_en=1, arm=0 and the block is capturing (armed and not yet done); ram_wdata always equals smp_data.
- R3: Every write advances ram_addr by one, modulo 2^AW, for the next cycle; cycles without a write leave ram_addr unchanged.
- R4: arm=1 writes nothing in that cycle. It sets ram_addr to 0, clears done, loads pre_segs and starts capture from the beginning, whatever the current state.
- R5: Triggers are ignored until pre_segs*2^SEG_LOG samples have been written since arming.
- R6: After the pre-trigger fill, a write cycle with trig_int=1 is the trigger cycle.
- R7: With pre_segs=0, a trigger is accepted on the very first write after arming.
- R8: In the trigger cycle, trig_addr takes the ram_addr of that write; it keeps that value at all other times.
- R9: The post-trigger capture is (2^(AW-SEG_LOG)-pre_segs)*2^SEG_LOG writes, including the trigger sample. After the last of them, done=1 and ram_we=0.
- R10: trig_ext counts as a trigger only while ext_trig_en=1.
- R11: A trigger input high in a cycle with smp_en=0 is ignored.
- R12: Once done, the block makes no writes and stays done until arm.
- R13: While waiting for a trigger, writing continues past the end of the buffer and wraps to address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| arm | input | 1 | Restart capture |
| pre_segs | input | AW-SEG_LOG | Pre-trigger size in segments, loaded on arm |
| ext_trig_en | input | 1 | Enables the external trigger |
| smp_en | input | 1 | Sample enable |
| smp_data | input | DW | Sample word |
| trig_int | input | 1 | Internal trigger |
| trig_ext | input | 1 | External trigger |
| ram_addr | output | AW | RAM write address |
| ram_wdata | output | DW | RAM write data |
| ram_we | output | 1 | RAM write enable |
| done | output | 1 | Capture complete |
| trig_addr | output | AW | Address of the trigger sample |

## Verification
The hardest case to reach is a trigger that lands after the write address has wrapped during a long wait, followed by a post-trigger run that wraps again. This needs hundreds of sample cycles, so the bench uses a small buffer of 256 words in 32-word segments. It feeds a stream with gaps in sample enable and holds triggers back for more than one lap of the ring. It also places ignored triggers in each phase: during the fill, on the disabled external pin, and without a sample enable. A second arm arrives in the middle of a fill to show that capture restarts.

// File: rtl/capture_ctrl.sv
module capture_ctrl #(
  parameter int AW      = 17,
  parameter int DW      = 32,
  parameter int SEG_LOG = 13
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 arm,
  input  logic [AW-SEG_LOG-1:0] pre_segs,
  input  logic                 ext_trig_en,
  input  logic                 smp_en,
  input  logic [DW-1:0]        smp_data,
  input  logic                 trig_int,
  input  logic                 trig_ext,
  output logic [AW-1:0]        ram_addr,
  output logic [DW-1:0]        ram_wdata,
  output logic                 ram_we,
  output logic                 done,
  output logic [AW-1:0]        trig_addr
);
  localparam int SW   = AW - SEG_LOG;
  localparam int NSEG = 1 << SW;

  typedef enum logic [2:0] {IDLE, PREFILL, WAIT_TRIG, POST, DONE} st_t;

  st_t           state;
  logic [SW-1:0] pre_q;
  logic [AW:0]   cnt, cnt_nx, pre_len, post_len;
  logic [SW:0]   segs_left;
  logic          active, hit;

  assign segs_left = (SW+1)'(NSEG) - {1'b0, pre_q};
  assign pre_len   = (AW+1)'(pre_q) << SEG_LOG;
  assign post_len  = (AW+1)'(segs_left) << SEG_LOG;
  assign cnt_nx    = cnt + 1'b1;

  assign active    = (state == PREFILL) || (state == WAIT_TRIG) || (state == POST);
  assign ram_we    = smp_en && active && !arm;
  assign ram_wdata = smp_data;
  assign hit       = ram_we && (state == WAIT_TRIG) && (trig_int || (ext_trig_en && trig_ext));
  assign done      = (state == DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= IDLE;
      ram_addr  <= '0;
      cnt       <= '0;
      pre_q     <= '0;
      trig_addr <= '0;
    end else if (arm) begin
      ram_addr <= '0;
      cnt      <= '0;
      pre_q    <= pre_segs;
      state    <= (pre_segs == '0) ? WAIT_TRIG : PREFILL;
    end else if (ram_we) begin
      ram_addr <= ram_addr + 1'b1;
      case (state)
        PREFILL: begin
          if (cnt_nx == pre_len) begin
            state <= WAIT_TRIG;
            cnt   <= '0;
          end else begin
            cnt <= cnt_nx;
          end
        end
        WAIT_TRIG: begin
          if (hit) begin
            trig_addr <= ram_addr;
            cnt       <= (AW+1)'(1);
            state     <= POST;
          end
        end
        POST: begin
          cnt <= cnt_nx;
          if (cnt_nx == post_len) state <= DONE;
        end
        default: ;
      endcase
    end
  end

  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |=> ram_addr == $past(ram_addr) + 1'b1);

  // R4
  arm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (ram_addr == '0) && !done);

  // R12
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !arm) |=> (done && !ram_we));

  // R8
  trig_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> $stable(trig_addr));

  // R5
  prefill_no_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PREFILL && !arm) |=> state != POST);

  // R9
  post_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == POST) |-> (cnt < post_len) && (cnt != '0));
endmodule

// File: tb/sim_capture_ctrl.sv
`timescale 1ns/1ps
module sim_capture_ctrl;
  localparam int AW = 8, DW = 16, SL = 5, SW = AW - SL, NSEG = 1 << SW, SEG = 1 << SL;

  logic clk = 0, rst_n = 0, arm = 0, ext_trig_en = 0, smp_en = 0, trig_int = 0, trig_ext = 0;
  logic [SW-1:0] pre_segs = '0;
  logic [DW-1:0] smp_data = '0;
  logic [AW-1:0] ram_addr, trig_addr;
  logic [DW-1:0] ram_wdata;
  logic ram_we, done;

  always #2.5 clk = ~clk;

  capture_ctrl #(.AW(AW), .DW(DW), .SEG_LOG(SL)) u0 (
    .clk, .rst_n, .arm, .pre_segs, .ext_trig_en, .smp_en, .smp_data,
    .trig_int, .trig_ext, .ram_addr, .ram_wdata, .ram_we, .done, .trig_addr);

  typedef struct packed {
    logic we; logic [AW-1:0] addr; logic [DW-1:0] data; logic dn; logic [AW-1:0] ta;
  } exp_t;
  exp_t q[$];

  int checks = 0, fails = 0;
  int mst = 0; // 0 idle 1 prefill 2 wait 3 post 4 done
  int mptr = 0, mcnt = 0, mpre = 0, mtrig = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(string tag, longint got, longint exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic step(bit en, bit ti, bit te, bit a = 0, int pre = 0);
    exp_t e;
    bit we, trg;
    @(negedge clk);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    smp_en = en; trig_int = ti; trig_ext = te; arm = a;
    pre_segs = SW'(pre); smp_data = lfsr;
    we = en && (mst >= 1 && mst <= 3) && !a;
    trg = ti || (ext_trig_en && te);
    e.we = we; e.addr = AW'(mptr); e.data = lfsr; e.dn = (mst == 4); e.ta = AW'(mtrig);
    q.push_back(e);
    if (a) begin
      mptr = 0; mcnt = 0; mpre = pre; mst = (pre == 0) ? 2 : 1;
    end else if (we) begin
      mptr = (mptr + 1) % (1 << AW);
      case (mst)
        1: begin mcnt++; if (mcnt == mpre * SEG) begin mst = 2; mcnt = 0; end end
        2: if (trg) begin mtrig = (mptr + (1 << AW) - 1) % (1 << AW); mcnt = 1; mst = 3; end
        3: begin mcnt++; if (mcnt == (NSEG - mpre) * SEG) mst = 4; end
        default: ;
      endcase
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk("R2 we", ram_we, e.we);
      chk("R2 wdata", ram_wdata, e.data);
      chk("R3 addr", ram_addr, e.addr);
      chk("R9 done", done, e.dn);
      chk("R8 trig_addr", trig_addr, e.ta);
    end
  end

  task automatic idle_peek();
    step(0, 0, 0);
    #1;
  endtask

  initial begin
    #(5.0 * 200000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk("R1 we", ram_we, 0); chk("R1 done", done, 0);
    chk("R1 addr", ram_addr, 0); chk("R1 trig_addr", trig_addr, 0);
    rst_n = 1;
    step(1, 1, 1); // R2 no write while idle
    idle_peek(); chk("R2 idle no write", ram_addr, 0);

    // Scenario A: pre=2 segments (64), R5 trigger during fill ignored
    step(0, 0, 0, 1, 2);
    for (int i = 0; i < 64; i++) begin
      if (i % 9 == 4) step(0, 0, 0);
      step(1, i == 10 || i == 63, i == 20);
    end
    idle_peek(); chk("R5 fill trigger ignored", trig_addr, 0);
    // R10 disabled external pin, R11 trigger without enable, R13 wrap during wait
    for (int i = 0; i < 250; i++) begin
      if (i == 5) step(0, 1, 0);
      step(1, 0, i == 30);
    end
    idle_peek(); chk("R10/R11 no trigger yet", trig_addr, 0);
    chk("R13 wrapped addr", ram_addr, (64 + 250) % 256);
    step(1, 1, 0); // R6 trigger accepted at addr 58
    idle_peek(); chk("R8 trig_addr", trig_addr, 58); chk("R6 post started", done, 0);
    for (int i = 0; i < 191; i++) step(1, i == 7, 0);
    idle_peek(); chk("R9 done", done, 1); chk("R9 final addr", ram_addr, (58 + 192) % 256);
    for (int i = 0; i < 10; i++) step(1, 1, 1);
    idle_peek(); chk("R12 still done", done, 1); chk("R12 addr frozen", ram_addr, 250);

    // Scenario B: pre=0, external trigger enabled; R7
    ext_trig_en = 1;
    step(0, 0, 0, 1, 0);
    idle_peek(); chk("R4 arm clears done", done, 0); chk("R4 arm clears addr", ram_addr, 0);
    step(1, 0, 1);
    idle_peek(); chk("R7 trig on first write", trig_addr, 0);
    for (int i = 0; i < 255; i++) step(1, 0, 0);
    idle_peek(); chk("R7 done after full ring", done, 1); chk("R9 ring end addr", ram_addr, 0);

    // Scenario C: pre=7, R4 re-arm during fill
    step(0, 0, 0, 1, 7);
    for (int i = 0; i < 20; i++) step(1, 0, 0);
    step(1, 1, 0, 1, 7);
    idle_peek(); chk("R4 rearm addr", ram_addr, 0);
    for (int i = 0; i < 224; i++) step(1, 0, i == 100);
    step(1, 0, 1); // external trigger at addr 224
    idle_peek(); chk("R10 ext trigger", trig_addr, 224);
    for (int i = 0; i < 31; i++) step(1, 0, 0);
    idle_peek(); chk("R9 short post done", done, 1); chk("R9 short post addr", ram_addr, 0);

    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule